// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM's contents alive. After reset it waits out a power-up pause, then runs a burst of CAS-before-RAS (CBR) cycles to wake the device. Only then does it raise `init_done`. After that, an interval timer marks each refresh slot, and the block issues one CBR cycle per slot. The device steps its own internal row counter, so no address is driven.

The block shares the DRAM pins with an access controller through a request/grant handshake. `req` rises when refresh work is owed and stays high until every owed cycle has been issued. `gnt` is the controller's answer, and the controller must hold it high for as long as `req` stays high. The sequencer pulls no strobe low until it has both asserted `req` and seen `gnt`. While `gnt` is withheld, the interval timer keeps running and missed slots are counted up to a cap. When the grant finally arrives, all owed cycles go out back to back. During every cycle the sequencer drives, the write and output enables stay inactive and the data bus is not driven.

All timing is expressed in clock cycles through parameters. The defaults assume a 100 MHz clock: 200 us of pause, 8 wake-up cycles, and one refresh about every 15 us. That pace covers 256 rows well inside 4 ms.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `req` and `init_done` are 0, `ras_n`, `ucas_n` and `lcas_n` are 1.
- R2: After reset is released, `req` stays 0 for exactly PWRUP_CYCLES clocks and rises on the clock after that; no RAS pulse occurs during the pause.
- R3: After the pause, exactly INIT_CYCLES CBR cycles are issued once granted. Then `init_done` rises and `req` falls on the same clock. `init_done` stays 1 until the next reset.
- R4: In every cycle, both CAS strobes (always equal) go low at least CAS_LEAD clocks before RAS falls and stay low for as long as RAS is low.
- R5: Each RAS low pulse lasts exactly RAS_LOW clocks, and RAS stays high for at least RAS_HIGH clocks between pulses.
- R6: A strobe is low only while both `req` and `gnt` are 1; with `gnt` withheld, no RAS pulse occurs.
- R7: After initialization, with `gnt` held high, successive RAS falls are exactly REFI_CYCLES clocks apart.
- R8: Refresh slots that elapse while `gnt` is low are counted. On grant they are all issued back to back, with RAS falls CAS_LEAD+RAS_LOW+RAS_HIGH clocks apart. The same spacing applies within the initialization burst.
- R9: The owed count saturates at MAX_OWED, so a long grant outage yields exactly MAX_OWED cycles.
- R10: `we_n` and `oe_n` are always 1 and `dq_oe` is always 0.
- R11: `req` stays high until the last owed cycle completes and is then 0 until the next refresh slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the pause and wake-up burst |
| gnt | input | 1 | Bus grant from the access controller |
| req | output | 1 | Bus request; high while refresh work is owed or running |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write enable, held inactive high |
| oe_n | output | 1 | Output enable, held inactive high |
| dq_oe | output | 1 | Data bus drive enable, held 0 |
| init_done | output | 1 | Memory ready after the wake-up burst |

## Verification
Faults in the pause counter or the wake-up counter appear at once as a `req` rise or `init_done` rise on the wrong clock, or as a wrong number of RAS pulses before ready. A slip in the strobe phase counter changes a RAS pulse width or the CAS lead on the very next cycle. A fault in the owed-slot counter only appears after a grant outage, as a burst with the wrong length. The bench therefore holds the grant back across known numbers of slots, both below and above the cap, and counts the pulses that follow.

// File: rtl/drfsh_pkg.sv
package drfsh_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ASK   = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/cbr_strobe_gen.sv
// One CBR cycle per start: CAS lead, RAS low, precharge. Restartable on its last clock.
module cbr_strobe_gen #(
  parameter int CAS_LEAD = 1,
  parameter int RAS_LOW  = 4,
  parameter int RAS_HIGH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic last,
  output logic ras_n,
  output logic cas_n
);
  localparam int CYC_LEN = CAS_LEAD + RAS_LOW + RAS_HIGH;
  localparam int CW      = $clog2(CYC_LEN + 1);

  logic          active;
  logic [CW-1:0] cnt;

  assign last = active && (cnt == CW'(CYC_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active && !last) begin
      cnt <= cnt + 1'b1;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else begin
      active <= 1'b0;
    end
  end

  assign cas_n = !(active && (cnt < CW'(CAS_LEAD + RAS_LOW)));
  assign ras_n = !(active && (cnt >= CW'(CAS_LEAD)) && (cnt < CW'(CAS_LEAD + RAS_LOW)));

  assert_cas_leads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  assert_cas_covers_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);
endmodule

// File: rtl/refi_timer.sv
// Interval timer plus saturating count of refresh slots still owed.
module refi_timer #(
  parameter int REFI_CYCLES = 1500,
  parameter int MAX_OWED    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic                           take,
  output logic                           tick,
  output logic [$clog2(MAX_OWED+1)-1:0]  owed
);
  localparam int TW = $clog2(REFI_CYCLES + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [TW-1:0] tcnt;

  assign tick = run && (tcnt == TW'(REFI_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!run || tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed <= '0;
    end else if (!run) begin
      owed <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
        2'b01:   if (owed != '0) owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assert_owed_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_OWED));
  assert_owed_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (owed > $past(owed)) |-> (owed == $past(owed) + 1'b1));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drfsh_pkg::*;
#(
  parameter int CAS_LEAD     = 1,
  parameter int RAS_LOW      = 4,
  parameter int RAS_HIGH     = 3,
  parameter int PWRUP_CYCLES = 20000,
  parameter int INIT_CYCLES  = 8,
  parameter int REFI_CYCLES  = 1500,
  parameter int MAX_OWED     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gnt,
  output logic req,
  output logic ras_n,
  output logic ucas_n,
  output logic lcas_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe,
  output logic init_done
);
  localparam int PW = $clog2(PWRUP_CYCLES + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  seq_state_t    state;
  logic [PW-1:0] pwr_cnt;
  logic [IW-1:0] init_left;
  logic [OW-1:0] owed;
  logic          tick, eng_last, eng_start, take, more, cas_n;

  refi_timer #(.REFI_CYCLES(REFI_CYCLES), .MAX_OWED(MAX_OWED)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done), .take(take), .tick(tick), .owed(owed)
  );

  cbr_strobe_gen #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_HIGH(RAS_HIGH)) u_strobe (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .last(eng_last), .ras_n(ras_n), .cas_n(cas_n)
  );

  always_comb begin
    if (!init_done) more = (init_left > IW'(1));
    else            more = (owed > OW'(1)) || tick;
  end

  assign take      = eng_last && init_done;
  assign eng_start = ((state == ST_ASK) && gnt) || ((state == ST_RUN) && eng_last && more);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PWRUP;
      pwr_cnt   <= '0;
      init_left <= '0;
      init_done <= 1'b0;
    end else begin
      case (state)
        ST_PWRUP: begin
          if (pwr_cnt == PW'(PWRUP_CYCLES - 1)) begin
            state     <= ST_ASK;
            init_left <= IW'(INIT_CYCLES);
          end else begin
            pwr_cnt <= pwr_cnt + 1'b1;
          end
        end
        ST_IDLE: if (owed != '0) state <= ST_ASK;
        ST_ASK:  if (gnt) state <= ST_RUN;
        ST_RUN: begin
          if (eng_last) begin
            if (!init_done) init_left <= init_left - 1'b1;
            if (!more) begin
              state     <= ST_IDLE;
              init_done <= 1'b1;
            end
          end
        end
        default: state <= ST_PWRUP;
      endcase
    end
  end

  assign req    = (state == ST_ASK) || (state == ST_RUN);
  assign ucas_n = cas_n;
  assign lcas_n = cas_n;
  assign we_n   = 1'b1;
  assign oe_n   = 1'b1;
  assign dq_oe  = 1'b0;

  assert_strobe_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !ucas_n) |-> req);
  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  assert_pause_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PWRUP) |-> (ras_n && !init_done));
endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CAS_LEAD = 1, RAS_LOW = 3, RAS_HIGH = 2;
  localparam int PWRUP = 20, INIT = 8, REFI = 100, MAXO = 8;
  localparam int CYC = CAS_LEAD + RAS_LOW + RAS_HIGH;

  logic clk = 1'b0, rst_n = 1'b0, gnt = 1'b0;
  logic req, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe, init_done;

  int checks = 0, failures = 0, cyc = 0;
  int falls = 0, last_fall = 0;
  int cas_lead = 0, low_run = 0, high_run = 0;
  bit prev_ras = 1'b1, seen_rise = 1'b0, done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(.CAS_LEAD(CAS_LEAD), .RAS_LOW(RAS_LOW), .RAS_HIGH(RAS_HIGH),
    .PWRUP_CYCLES(PWRUP), .INIT_CYCLES(INIT), .REFI_CYCLES(REFI), .MAX_OWED(MAXO)) dut (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .ras_n(ras_n), .ucas_n(ucas_n),
    .lcas_n(lcas_n), .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .init_done(init_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Pin monitor on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ras = 1'b1; seen_rise = 1'b0; cas_lead = 0; low_run = 0; high_run = 0;
    end else begin
      chk(we_n && oe_n && !dq_oe, "R10 enables idle", {we_n, oe_n, dq_oe}, 3'b110);
      chk(ucas_n == lcas_n, "R4 byte strobes equal", ucas_n, lcas_n);
      chk(ras_n || !ucas_n, "R4 CAS low during RAS low", ucas_n, 0);
      chk((ras_n && ucas_n) || (req && gnt), "R6 strobe without grant", {req, gnt}, 2'b11);
      if (prev_ras && !ras_n) begin
        falls++;
        last_fall = cyc;
        chk(cas_lead >= CAS_LEAD, "R4 CAS lead", cas_lead, CAS_LEAD);
        if (seen_rise) chk(high_run >= RAS_HIGH, "R5 RAS high time", high_run, RAS_HIGH);
        low_run = 1;
      end else if (!ras_n) begin
        low_run++;
      end
      if (!prev_ras && ras_n) begin
        chk(low_run == RAS_LOW, "R5 RAS low width", low_run, RAS_LOW);
        seen_rise = 1'b1;
        high_run = 1;
      end else if (ras_n) begin
        high_run++;
      end
      if (!ras_n) cas_lead = 0;
      else if (!ucas_n) cas_lead++;
      else cas_lead = 0;
      prev_ras = ras_n;
    end
  end

  task automatic check_reset_and_pause(input string ctx);
    int n, f0;
    rst_n = 1'b0;
    repeat (3) step();
    chk(!req && ras_n && ucas_n && lcas_n && !init_done, {"R1 reset state ", ctx},
        {req, ras_n, ucas_n, lcas_n, init_done}, 5'b01110);
    f0 = falls;
    rst_n = 1'b1;
    n = 0;
    while (!req && n < 10 * PWRUP) begin step(); n++; end
    chk(n == PWRUP, {"R2 pause length ", ctx}, n, PWRUP);
    chk(falls == f0, {"R2 no pulse in pause ", ctx}, falls - f0, 0);
  endtask

  // Grant now and collect the burst until req drops
  task automatic grant_burst(output int cnt, output int span);
    int f0, first, n;
    f0 = falls; first = 0; n = 0;
    gnt = 1'b1;
    while (req && n < 2000) begin
      step(); n++;
      if (falls == f0 + 1 && first == 0) first = last_fall;
    end
    cnt = falls - f0;
    span = last_fall - first;
  endtask

  task automatic backlog(input int k, input int expect_n, input string tag);
    int cnt, span, n;
    n = 0;
    while (req && n < 2000) begin step(); n++; end
    gnt = 1'b0;
    n = 0;
    while (!req && n < 2 * REFI) begin step(); n++; end
    repeat ((k - 1) * REFI + 10) step();
    grant_burst(cnt, span);
    chk(cnt == expect_n, {tag, " burst count"}, cnt, expect_n);
    chk(span == (expect_n - 1) * CYC, "R8 back-to-back spacing", span, (expect_n - 1) * CYC);
    repeat (20) step();
    chk(!req, "R11 req stays low after burst", req, 0);
  endtask

  initial begin
    int cnt, span, f0, t0, t1, t2, n;
    check_reset_and_pause("first");
    f0 = falls;
    repeat (10) step();
    chk(req && falls == f0, "R6 no pulse before grant", falls - f0, 0);
    // initialization burst
    f0 = falls;
    grant_burst(cnt, span);
    chk(init_done, "R3 init_done with req drop", init_done, 1);
    chk(cnt == INIT, "R3 init burst count", cnt, INIT);
    chk(span == (INIT - 1) * CYC, "R8 init spacing", span, (INIT - 1) * CYC);
    // periodic refresh with grant held
    n = falls; while (falls == n) step(); t0 = last_fall;
    n = falls; while (falls == n) step(); t1 = last_fall;
    n = falls; while (falls == n) step(); t2 = last_fall;
    chk(t1 - t0 == REFI, "R7 refresh interval a", t1 - t0, REFI);
    chk(t2 - t1 == REFI, "R7 refresh interval b", t2 - t1, REFI);
    chk(init_done, "R3 init_done sticky", init_done, 1);
    backlog(3, 3, "R8");
    backlog(1, 1, "R8");
    backlog(12, MAXO, "R9");
    // reset mid-operation restarts everything
    gnt = 1'b0;
    check_reset_and_pause("again");
    grant_burst(cnt, span);
    chk(cnt == INIT, "R3 re-init burst count", cnt, INIT);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule